// File: doc/BRIEF.md
# Warp Lane Mask Stack for Divergent Branches

This block tracks which of the 32 lanes of one warp are live while the warp runs through nested if/else code. Each branch instruction carries an operation code. A split operation saves the live mask on a private last-in-first-out store and narrows the live mask to the lanes whose predicate bit is set. A flip operation, placed at the end of the first path, turns on the lanes that were live before the split but did not take the first path. A join operation, placed at the convergence point, restores the saved mask. While the warp runs both paths, lanes outside the live mask do not commit their results.

The live mask gates writeback. The block also raises a one-cycle skip hint when the path about to run has no live lanes, or when the split did not divide the lanes at all, so the issue logic can jump over the empty path. Nesting depth is a parameter. A split on a full store and a join or flip on an empty store are refused and raise a one-cycle error pulse.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, and after any later reset, `active_mask_o` is all ones and `depth_o` is 0.
- R2: With `op_i` = 2'b01 (split) and the store not full, the next cycle shows `active_mask_o` = old mask AND `pred_i`, and `depth_o` is one higher.
- R3: With `op_i` = 2'b10 (flip) and the store not empty, the next cycle shows `active_mask_o` = saved top mask AND NOT old mask, and `depth_o` is unchanged.
- R4: With `op_i` = 2'b11 (join) and the store not empty, the next cycle shows `active_mask_o` equal to the most recently saved mask, and `depth_o` is one lower.
- R5: A split while `depth_o` equals DEPTH leaves the mask and depth unchanged and pulses `overflow_o` for one cycle.
- R6: A join or flip while `depth_o` is 0 leaves the mask and depth unchanged and pulses `underflow_o` for one cycle.
- R7: `uniform_o` pulses for one cycle after an accepted split whose new mask is all zeros or equals the old mask, and after an accepted flip whose new mask is all zeros. It stays low otherwise.
- R8: `commit_o` equals `active_mask_o` AND `wr_req_i` in the same cycle, so a lane outside the mask never commits.
- R9: With `op_i` = 2'b00, the mask and depth hold whatever `pred_i` carries, and all three flags stay low.
- R10: Saved masks come back in reverse order of saving through DEPTH levels of nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Branch marker: 00 none, 01 split, 10 flip, 11 join |
| pred_i | input | LANES | Per-lane predicate bits for a split |
| wr_req_i | input | LANES | Per-lane writeback requests |
| active_mask_o | output | LANES | Current live lane mask |
| commit_o | output | LANES | Writeback enables after masking |
| depth_o | output | $clog2(DEPTH+1) | Number of saved masks |
| uniform_o | output | 1 | Pulse: the path ahead is empty or the split did not divide the lanes |
| overflow_o | output | 1 | Pulse: split refused because the store is full |
| underflow_o | output | 1 | Pulse: join or flip refused because the store is empty |

## Verification
The bench checks the flip mask against the saved top, not against all ones. A design that inverts the whole word would wake lanes that were dead before the split. It pushes to full depth and then pushes once more, to catch a design that overwrites the top entry or changes the mask on refusal. It joins and flips on an empty store, where a wrap-around pointer would restore garbage. It nests a split inside an already empty path, to catch a skip hint that compares against the wrong mask. It also resets with masks still saved and then joins, which shows whether the depth was cleared.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_COMP = 2'b10,
    OP_POP  = 2'b11
  } mask_op_e;
endpackage

// File: rtl/simt_mask_lifo.sv
module simt_mask_lifo #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] din_i,
  output logic [LANES-1:0] top_o,
  output logic [DW-1:0]    depth_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    depth_q;
  logic [LANES-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '1;
      else if (push_i && depth_q == DW'(i))    mem_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     depth_q <= '0;
    else if (push_i) depth_q <= depth_q + DW'(1);
    else if (pop_i)  depth_q <= depth_q - DW'(1);
  end

  always_comb begin
    top_o = '1;
    for (int i = 0; i < DEPTH; i++)
      if (depth_q == DW'(i + 1)) top_o = mem_q[i];
  end

  assign depth_o = depth_q;
  assign full_o  = (depth_q == DW'(DEPTH));
  assign empty_o = (depth_q == '0);
endmodule

// File: rtl/simt_mask_next.sv
module simt_mask_next
  import simt_mask_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  mask_op_e         op_i,
  input  logic [LANES-1:0] cur_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] top_i,
  input  logic             full_i,
  input  logic             empty_i,
  output logic [LANES-1:0] nxt_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             uni_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [LANES-1:0] split_m, flip_m;

  assign split_m = cur_i & pred_i;
  assign flip_m  = top_i & ~cur_i;   // other path, limited to lanes live before split

  always_comb begin
    nxt_o  = cur_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    uni_o  = 1'b0;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    unique case (op_i)
      OP_PUSH: begin
        if (full_i) ovf_o = 1'b1;
        else begin
          nxt_o  = split_m;
          push_o = 1'b1;
          uni_o  = (split_m == '0) || (split_m == cur_i);
        end
      end
      OP_COMP: begin
        if (empty_i) unf_o = 1'b1;
        else begin
          nxt_o = flip_m;
          uni_o = (flip_m == '0);
        end
      end
      OP_POP: begin
        if (empty_i) unf_o = 1'b1;
        else begin
          nxt_o = top_i;
          pop_o = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] wr_req_i,
  output logic [LANES-1:0] active_mask_o,
  output logic [LANES-1:0] commit_o,
  output logic [DW-1:0]    depth_o,
  output logic             uniform_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  logic [LANES-1:0] mask_q, mask_d, top;
  logic             push, pop, uni, ovf, unf, full, empty;
  logic             uni_q, ovf_q, unf_q;

  simt_mask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) lifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (mask_q),
    .top_o   (top),
    .depth_o (depth_o),
    .full_o  (full),
    .empty_o (empty)
  );

  simt_mask_next #(.LANES(LANES)) next_i (
    .op_i    (mask_op_e'(op_i)),
    .cur_i   (mask_q),
    .pred_i  (pred_i),
    .top_i   (top),
    .full_i  (full),
    .empty_i (empty),
    .nxt_o   (mask_d),
    .push_o  (push),
    .pop_o   (pop),
    .uni_o   (uni),
    .ovf_o   (ovf),
    .unf_o   (unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      uni_q  <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      uni_q  <= uni;
      ovf_q  <= ovf;
      unf_q  <= unf;
    end
  end

  assign active_mask_o = mask_q;
  assign commit_o      = mask_q & wr_req_i;
  assign uniform_o     = uni_q;
  assign overflow_o    = ovf_q;
  assign underflow_o   = unf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       op_i,
  input logic [LANES-1:0] pred_i,
  input logic [LANES-1:0] active_mask_o,
  input logic [DW-1:0]    depth_o,
  input logic             uniform_o,
  input logic             overflow_o,
  input logic             underflow_o
);
  assert_base_all_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o == '0 |-> active_mask_o == '1);

  assert_push_narrows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && depth_o != DW'(DEPTH)) |=>
      (active_mask_o == ($past(active_mask_o) & $past(pred_i)) && depth_o == $past(depth_o) + DW'(1)));

  assert_comp_disjoint_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10 && depth_o != '0) |=>
      ((active_mask_o & $past(active_mask_o)) == '0 && $stable(depth_o)));

  assert_pop_depth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11 && depth_o != '0) |=> depth_o == $past(depth_o) - DW'(1));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && depth_o == DW'(DEPTH)) |=>
      (overflow_o && $stable(active_mask_o) && $stable(depth_o)));

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[1] && depth_o == '0) |=> (underflow_o && $stable(active_mask_o) && $stable(depth_o)));

  assert_uniform_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && depth_o != DW'(DEPTH) && (active_mask_o & pred_i) == '0) |=> uniform_o);

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({uniform_o, overflow_o, underflow_o}) <= 1);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |=> ($stable(active_mask_o) && $stable(depth_o) && !uniform_o && !overflow_o && !underflow_o));
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_i          (op_i),
  .pred_i        (pred_i),
  .active_mask_o (active_mask_o),
  .depth_o       (depth_o),
  .uniform_o     (uniform_o),
  .overflow_o    (overflow_o),
  .underflow_o   (underflow_o)
);

// File: tb/simt_mask_stack_tb_top.sv
`timescale 1ns/1ps
module simt_mask_stack_tb_top;
  localparam int unsigned LANES = 32;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned DW    = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] pred;
    logic [31:0] mask;
    logic [2:0]  depth;
    logic        uni;
    logic        ovf;
    logic        unf;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 32'h0000FFFF, 32'h0000FFFF, 3'd1, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'h000000FF, 32'h000000FF, 3'd2, 1'b0, 1'b0, 1'b0},
    '{2'b10, 32'h00000000, 32'h0000FF00, 3'd2, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'h0000FFFF, 3'd1, 1'b0, 1'b0, 1'b0},
    '{2'b10, 32'h00000000, 32'hFFFF0000, 3'd1, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'd1, 1'b1, 1'b0, 1'b0},
    '{2'b10, 32'h00000000, 32'h00000000, 3'd1, 1'b1, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'h00000000, 32'h00000000, 3'd1, 1'b1, 1'b0, 1'b0},
    '{2'b01, 32'hAAAAAAAA, 32'h00000000, 3'd2, 1'b1, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'h00000000, 3'd1, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 1'b1},
    '{2'b10, 32'h00000000, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 1'b1},
    '{2'b01, 32'h12345678, 32'h12345678, 3'd1, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'hF0F0F0F0, 32'h10305070, 3'd2, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'h0000FFFF, 32'h00005070, 3'd3, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'h00001000, 32'h00001000, 3'd4, 1'b0, 1'b0, 1'b0},
    '{2'b01, 32'hFFFFFFFF, 32'h00001000, 3'd4, 1'b0, 1'b1, 1'b0},
    '{2'b00, 32'h5A5A5A5A, 32'h00001000, 3'd4, 1'b0, 1'b0, 1'b0},
    '{2'b10, 32'h00000000, 32'h00004070, 3'd4, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'h00005070, 3'd3, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'h10305070, 3'd2, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'h12345678, 3'd1, 1'b0, 1'b0, 1'b0},
    '{2'b11, 32'h00000000, 32'hFFFFFFFF, 3'd0, 1'b0, 1'b0, 1'b0}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       op_i = 2'b00;
  logic [LANES-1:0] pred_i = '0;
  logic [LANES-1:0] wr_req_i = '0;
  logic [LANES-1:0] active_mask_o, commit_o;
  logic [DW-1:0]    depth_o;
  logic             uniform_o, overflow_o, underflow_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .op_i, .pred_i, .wr_req_i,
    .active_mask_o, .commit_o, .depth_o,
    .uniform_o, .overflow_o, .underflow_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] pred);
    op_i = op;
    pred_i = pred;
    @(negedge clk_i);
    op_i = 2'b00;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset mask", active_mask_o, 32'hFFFFFFFF);
    chk("R1 reset depth", 32'(depth_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      string tag;
      case (VECS[i].op)
        2'b01:   tag = "R2/R10 split";
        2'b10:   tag = "R3 flip";
        2'b11:   tag = "R4/R10 join";
        default: tag = "R9 idle";
      endcase
      step(VECS[i].op, VECS[i].pred);
      chk($sformatf("%s mask v%0d", tag, i), active_mask_o, VECS[i].mask);
      chk($sformatf("%s depth v%0d", tag, i), 32'(depth_o), 32'(VECS[i].depth));
      chk($sformatf("R7 uniform v%0d", i), 32'(uniform_o), 32'(VECS[i].uni));
      chk($sformatf("R5 overflow v%0d", i), 32'(overflow_o), 32'(VECS[i].ovf));
      chk($sformatf("R6 underflow v%0d", i), 32'(underflow_o), 32'(VECS[i].unf));
    end

    // R8: commit gating
    step(2'b01, 32'h12345678);
    wr_req_i = 32'h0000FFFF;
    #1;
    chk("R8 commit partial", commit_o, 32'h00005678);
    wr_req_i = 32'hFFFFFFFF;
    #1;
    chk("R8 commit full", commit_o, 32'h12345678);
    wr_req_i = '0;

    // R1: reset with saved masks, then join must underflow
    step(2'b01, 32'h000000F0);
    chk("R2 nested depth", 32'(depth_o), 2);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 re-reset mask", active_mask_o, 32'hFFFFFFFF);
    chk("R1 re-reset depth", 32'(depth_o), 0);
    step(2'b11, 32'h0);
    chk("R6 join after reset", 32'(underflow_o), 1);
    chk("R6 mask after reset join", active_mask_o, 32'hFFFFFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule